// File: doc/BRIEF.md
# Shared-Segment Transmit FIR Tap Allocator

This block is the digital side of a five-tap equalizing line driver. The analog output stage is split two ways. One part is a pool of large coarse segments, each worth sixteen current units, that can be handed to any tap. The other part is one small binary-weighted fine segment per tap, worth up to fifteen units. Every symbol period the block takes the incoming 2-bit symbol and keeps a four-deep history of it, so the five taps see the current symbol and the four before it. It combines that history with the five configured signed tap weights and produces an enable, polarity and swing bit for every segment. The currents summed at the pad then equal the FIR output.

Software-free operation is assumed: a new weight set is presented on a wide configuration word together with a one-cycle load strobe. The block checks the new set against the peak-drive limit. If the set fits, the block splits each weight into a coarse count and a fine remainder and lays the coarse counts out over the pool in tap order. A set that does not fit is refused with an error flag, and the previous allocation stays in force. All segment controls leave registers, so a weight change switches at a symbol boundary with no intermediate code at the outputs.

Top module: `fir_tx_seg_alloc`

## Requirements
- R1: While `rst_n` is low, every segment control output and `cfg_err` is 0, all active tap weights are zero, and the symbol history is cleared.
- R2: A symbol code carries polarity in bit 1 (1 = positive) and swing in bit 0 (0 = full swing, level 3; 1 = reduced swing, level 1). Codes 00, 01, 11 and 10 therefore mean -3, -1, +1 and +3. A driven segment reports the swing on its `*_big` bit (1 = level 3).
- R3: Tap k (k = 0 for A up to 4 for E) uses the symbol sampled k clock edges before tap A's symbol. The symbol present on `sym_in` at edge n first affects tap A's segment words after edge n+1, and tap k's words after edge n+1+k.
- R4: `cfg_wt` holds one 8-bit field per tap, tap A in bits 7:0 and tap E in bits 39:32. Bit 7 of a field is the tap sign (1 = inverted) and bits 6:0 are the magnitude. The coarse count is magnitude/16 and the fine remainder is magnitude mod 16.
- R5: Coarse segments are assigned from segment 0 upward, first to tap A for its coarse count, then to B, C, D and E. Unassigned segments drive enable, polarity and swing all 0, so the enabled coarse segments always form a contiguous run starting at bit 0.
- R6: Bits `fin_en[4k+3:4k]` equal tap k's fine remainder, and bit b is worth 2^b units. A tap whose remainder is 0 drives `fin_pol[k]` and `fin_big[k]` at 0.
- R7: The polarity of every driven segment of tap k is the symbol polarity of tap k XOR the tap sign, where 1 means positive current.
- R8: A load whose five magnitudes sum above 127 is refused: `cfg_err` becomes 1 after that edge and the allocation in use does not change. An accepted load clears `cfg_err`. The total drive magnitude at the outputs never exceeds 127 units.
- R9: Weights loaded at edge n are used by the segment words registered at edge n+1. The words registered at edge n still use the previous weights.
- R10: The signed sum of all driven segment contributions, each worth its unit weight times ±1 polarity times its level, equals the dot product of the tap weights with the tap symbol levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 2 | Transmit symbol, Gray-coded |
| cfg_load | input | 1 | One-cycle strobe to accept `cfg_wt` |
| cfg_wt | input | 40 | Five signed tap weights, 8 bits each |
| cfg_err | output | 1 | Last load was refused for exceeding the drive limit |
| crs_en | output | 7 | Coarse segment enables |
| crs_pol | output | 7 | Coarse segment polarities |
| crs_big | output | 7 | Coarse segment full-swing selects |
| fin_en | output | 20 | Fine segment bit enables, 4 per tap |
| fin_pol | output | 5 | Fine segment polarity per tap |
| fin_big | output | 5 | Fine segment full-swing select per tap |

## Verification
On every cycle, the embedded properties check several things. The enabled coarse segments must stay a packed run from bit 0. Idle segments must drive no polarity or swing. The total drive magnitude must remain within full scale. A refused load must leave the allocation untouched and raise the flag, and an accepted load must be adopted. What no property can show is that the signed pad current equals the correct FIR value for a particular history: that depends on the tap delay, the Gray level mapping and the sign XOR acting together. The bench shows this through its own per-cycle reference and through directed impulse, sign-flip and pool-exhaustion scenarios.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int TAPS_DEF  = 5;
  localparam int CRS_DEF   = 7;
  localparam int FIN_W_DEF = 4;
  localparam int MAG_W_DEF = 7;

  // bit 1 of a Gray symbol code: 1 = positive level
  function automatic logic sym_positive(input logic [1:0] code);
    return code[1];
  endfunction

  // bit 0 clear selects the outer (level 3) swing
  function automatic logic sym_full(input logic [1:0] code);
    return ~code[0];
  endfunction
endpackage

// File: rtl/tfa_sym_hist.sv
module tfa_sym_hist #(
  parameter int NTAP = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            sym_in,
  output logic [NTAP-1:0][1:0]  tap_sym
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_sym <= '0;
    end else begin
      tap_sym[0] <= sym_in;
      for (int k = 1; k < NTAP; k++) tap_sym[k] <= tap_sym[k-1];
    end
  end
endmodule

// File: rtl/tfa_cfg_gate.sv
module tfa_cfg_gate #(
  parameter int NTAP  = 5,
  parameter int MAG_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NTAP*(MAG_W+1)-1:0]     wt_in,
  output logic [NTAP-1:0][MAG_W-1:0]    act_mag,
  output logic [NTAP-1:0]               act_sgn,
  output logic                          cfg_err
);
  localparam int WT_W   = MAG_W + 1;
  localparam int SUM_W  = MAG_W + $clog2(NTAP) + 1;
  localparam int FULL_U = (1 << MAG_W) - 1;

  logic [SUM_W-1:0] mag_sum;
  logic             load_bad;
  logic [NTAP*WT_W-1:0] act_flat;

  always_comb begin
    mag_sum = '0;
    for (int k = 0; k < NTAP; k++)
      mag_sum = mag_sum + SUM_W'(wt_in[k*WT_W +: MAG_W]);
    load_bad = (mag_sum > SUM_W'(FULL_U));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mag <= '0;
      act_sgn <= '0;
      cfg_err <= 1'b0;
    end else if (load) begin
      if (load_bad) begin
        cfg_err <= 1'b1;
      end else begin
        cfg_err <= 1'b0;
        for (int k = 0; k < NTAP; k++) begin
          act_mag[k] <= wt_in[k*WT_W +: MAG_W];
          act_sgn[k] <= wt_in[k*WT_W + MAG_W];
        end
      end
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_flat
    assign act_flat[k*WT_W +: WT_W] = {act_sgn[k], act_mag[k]};
  end

  // R8
  reject_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_bad) |=> $stable(act_flat));
  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_bad) |=> cfg_err);
  // R9
  accept_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_bad) |=> (act_flat == $past(wt_in)) && !cfg_err);
endmodule

// File: rtl/tfa_seg_map.sv
module tfa_seg_map #(
  parameter int NTAP  = 5,
  parameter int NCRS  = 7,
  parameter int FIN_W = 4,
  parameter int MAG_W = 7
) (
  input  logic [NTAP-1:0][MAG_W-1:0] act_mag,
  input  logic [NTAP-1:0]            act_sgn,
  input  logic [NTAP-1:0][1:0]       tap_sym,
  output logic [NCRS-1:0]            crs_en,
  output logic [NCRS-1:0]            crs_pol,
  output logic [NCRS-1:0]            crs_big,
  output logic [NTAP*FIN_W-1:0]      fin_en,
  output logic [NTAP-1:0]            fin_pol,
  output logic [NTAP-1:0]            fin_big
);
  localparam int CW = MAG_W - FIN_W;
  localparam int BW = $clog2(NTAP * (1 << CW) + 1);

  logic [CW-1:0] cnt  [NTAP];
  logic [BW-1:0] base [NTAP];

  // running start index of each tap's slice of the coarse pool
  always_comb begin
    for (int k = 0; k < NTAP; k++) cnt[k] = act_mag[k][MAG_W-1:FIN_W];
    base[0] = '0;
    for (int k = 1; k < NTAP; k++) base[k] = base[k-1] + BW'(cnt[k-1]);
  end

  for (genvar j = 0; j < NCRS; j++) begin : g_crs
    logic hit_en, hit_pol, hit_big;
    always_comb begin
      hit_en  = 1'b0;
      hit_pol = 1'b0;
      hit_big = 1'b0;
      for (int k = 0; k < NTAP; k++) begin
        if ((BW'(j) >= base[k]) && (BW'(j) < base[k] + BW'(cnt[k]))) begin
          hit_en  = 1'b1;
          hit_pol = tfa_pkg::sym_positive(tap_sym[k]) ^ act_sgn[k];
          hit_big = tfa_pkg::sym_full(tap_sym[k]);
        end
      end
    end
    assign crs_en[j]  = hit_en;
    assign crs_pol[j] = hit_pol;
    assign crs_big[j] = hit_big;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_fin
    logic fin_live;
    assign fin_live = |act_mag[k][FIN_W-1:0];
    assign fin_en[k*FIN_W +: FIN_W] = act_mag[k][FIN_W-1:0];
    assign fin_pol[k] = fin_live & (tfa_pkg::sym_positive(tap_sym[k]) ^ act_sgn[k]);
    assign fin_big[k] = fin_live & tfa_pkg::sym_full(tap_sym[k]);
  end
endmodule

// File: rtl/fir_tx_seg_alloc.sv
module fir_tx_seg_alloc #(
  parameter int NTAP  = tfa_pkg::TAPS_DEF,
  parameter int NCRS  = tfa_pkg::CRS_DEF,
  parameter int FIN_W = tfa_pkg::FIN_W_DEF,
  parameter int MAG_W = tfa_pkg::MAG_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  sym_in,
  input  logic                        cfg_load,
  input  logic [NTAP*(MAG_W+1)-1:0]   cfg_wt,
  output logic                        cfg_err,
  output logic [NCRS-1:0]             crs_en,
  output logic [NCRS-1:0]             crs_pol,
  output logic [NCRS-1:0]             crs_big,
  output logic [NTAP*FIN_W-1:0]       fin_en,
  output logic [NTAP-1:0]             fin_pol,
  output logic [NTAP-1:0]             fin_big
);
  localparam int CRS_UNIT = 1 << FIN_W;
  localparam int FULL_U   = (1 << MAG_W) - 1;

  logic [NTAP-1:0][1:0]       tap_sym;
  logic [NTAP-1:0][MAG_W-1:0] act_mag;
  logic [NTAP-1:0]            act_sgn;
  logic [NCRS-1:0]            crs_en_n, crs_pol_n, crs_big_n;
  logic [NTAP*FIN_W-1:0]      fin_en_n;
  logic [NTAP-1:0]            fin_pol_n, fin_big_n;

  tfa_sym_hist #(.NTAP(NTAP)) u_hist (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .tap_sym(tap_sym)
  );

  tfa_cfg_gate #(.NTAP(NTAP), .MAG_W(MAG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .wt_in(cfg_wt),
    .act_mag(act_mag), .act_sgn(act_sgn), .cfg_err(cfg_err)
  );

  tfa_seg_map #(.NTAP(NTAP), .NCRS(NCRS), .FIN_W(FIN_W), .MAG_W(MAG_W)) u_map (
    .act_mag(act_mag), .act_sgn(act_sgn), .tap_sym(tap_sym),
    .crs_en(crs_en_n), .crs_pol(crs_pol_n), .crs_big(crs_big_n),
    .fin_en(fin_en_n), .fin_pol(fin_pol_n), .fin_big(fin_big_n)
  );

  // segment words change only at the clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_en  <= '0;
      crs_pol <= '0;
      crs_big <= '0;
      fin_en  <= '0;
      fin_pol <= '0;
      fin_big <= '0;
    end else begin
      crs_en  <= crs_en_n;
      crs_pol <= crs_pol_n;
      crs_big <= crs_big_n;
      fin_en  <= fin_en_n;
      fin_pol <= fin_pol_n;
      fin_big <= fin_big_n;
    end
  end

  // observation wires for the properties
  logic [NCRS:0]   crs_fill;
  logic [NTAP-1:0] fin_any;
  int              out_units;

  assign crs_fill = {1'b0, crs_en} + (NCRS+1)'(1);
  for (genvar k = 0; k < NTAP; k++) begin : g_any
    assign fin_any[k] = |fin_en[k*FIN_W +: FIN_W];
  end

  always_comb begin
    out_units = CRS_UNIT * int'($countones(crs_en));
    for (int k = 0; k < NTAP; k++)
      for (int b = 0; b < FIN_W; b++)
        if (fin_en[k*FIN_W + b]) out_units = out_units + (1 << b);
  end

  // R5
  coarse_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(crs_fill) == 1);
  // R5
  idle_seg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((crs_pol | crs_big) & ~crs_en) == '0);
  // R6
  fine_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fin_pol | fin_big) & ~fin_any) == '0);
  // R8
  peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_units <= FULL_U);
endmodule

// File: tb/fir_tx_seg_alloc_tb.sv
module fir_tx_seg_alloc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sym_in = 2'b00;
  logic        cfg_load = 1'b0;
  logic [39:0] cfg_wt = '0;
  logic        cfg_err;
  logic [6:0]  crs_en, crs_pol, crs_big;
  logic [19:0] fin_en;
  logic [4:0]  fin_pol, fin_big;

  int n_total = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;
  bit ended   = 1'b0;

  always #10 clk = ~clk;

  fir_tx_seg_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .cfg_load(cfg_load), .cfg_wt(cfg_wt),
    .cfg_err(cfg_err), .crs_en(crs_en), .crs_pol(crs_pol), .crs_big(crs_big),
    .fin_en(fin_en), .fin_pol(fin_pol), .fin_big(fin_big)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  // ---------------- reference model ----------------
  int m_d[5];
  int m_mag[5];
  int m_sgn[5];
  logic [6:0]  e_crs_en, e_crs_pol, e_crs_big;
  logic [19:0] e_fin_en;
  logic [4:0]  e_fin_pol, e_fin_big;
  logic        e_err;
  int          e_dot;

  function automatic int lvl(input int code);
    int v;
    v = ((code & 1) == 0) ? 3 : 1;
    return ((code >> 1) & 1) ? v : -v;
  endfunction

  always @(posedge clk) begin : mdl
    int nxt, tot, pos, sg;
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin m_d[k] = 0; m_mag[k] = 0; m_sgn[k] = 0; end
      e_crs_en = '0; e_crs_pol = '0; e_crs_big = '0;
      e_fin_en = '0; e_fin_pol = '0; e_fin_big = '0;
      e_err = 1'b0; e_dot = 0;
    end else begin
      nxt = 0;
      e_crs_en = '0; e_crs_pol = '0; e_crs_big = '0;
      e_fin_en = '0; e_fin_pol = '0; e_fin_big = '0;
      e_dot = 0;
      for (int k = 0; k < 5; k++) begin
        pos = lvl(m_d[k]) > 0 ? 1 : 0;
        for (int c = 0; c < m_mag[k] / 16; c++) begin
          e_crs_en[nxt]  = 1'b1;
          e_crs_pol[nxt] = 1'(pos ^ m_sgn[k]);
          e_crs_big[nxt] = ((m_d[k] & 1) == 0);
          nxt++;
        end
        e_fin_en[k*4 +: 4] = 4'(m_mag[k] % 16);
        if (m_mag[k] % 16 != 0) begin
          e_fin_pol[k] = 1'(pos ^ m_sgn[k]);
          e_fin_big[k] = ((m_d[k] & 1) == 0);
        end
        sg = m_sgn[k] ? -1 : 1;
        e_dot += sg * m_mag[k] * lvl(m_d[k]);
      end
      for (int k = 4; k > 0; k--) m_d[k] = m_d[k-1];
      m_d[0] = int'(sym_in);
      if (cfg_load) begin
        tot = 0;
        for (int k = 0; k < 5; k++) tot += int'(cfg_wt[k*8 +: 7]);
        if (tot > 127) e_err = 1'b1;
        else begin
          e_err = 1'b0;
          for (int k = 0; k < 5; k++) begin
            m_mag[k] = int'(cfg_wt[k*8 +: 7]);
            m_sgn[k] = int'(cfg_wt[k*8 + 7]);
          end
        end
      end
    end
  end

  function automatic int out_drive();
    int s = 0;
    for (int j = 0; j < 7; j++)
      if (crs_en[j]) s += (crs_pol[j] ? 1 : -1) * (crs_big[j] ? 3 : 1) * 16;
    for (int k = 0; k < 5; k++)
      for (int b = 0; b < 4; b++)
        if (fin_en[k*4 + b]) s += (fin_pol[k] ? 1 : -1) * (fin_big[k] ? 3 : 1) * (1 << b);
    return s;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(crs_en == e_crs_en, "R5 coarse enables", crs_en, e_crs_en);
      chk(fin_en == e_fin_en, "R6 fine enables", fin_en, e_fin_en);
      chk({crs_pol, fin_pol} == {e_crs_pol, e_fin_pol}, "R7 polarities",
          {crs_pol, fin_pol}, {e_crs_pol, e_fin_pol});
      chk({crs_big, fin_big} == {e_crs_big, e_fin_big}, "R2 swing bits",
          {crs_big, fin_big}, {e_crs_big, e_fin_big});
      chk(cfg_err == e_err, "R8 error flag", cfg_err, e_err);
      chk(out_drive() == e_dot, "R10 summed drive", out_drive(), e_dot);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [39:0] w);
    cfg_wt = w;
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  function automatic logic [7:0] wf(input bit s, input int m);
    return {s, 7'(m)};
  endfunction

  initial begin
    int p[6];
    logic [39:0] rw;
    int rem, mg;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cfg_err, crs_en, crs_pol, crs_big, fin_en, fin_pol, fin_big} == '0,
        "R1 reset outputs", {crs_en, fin_en}, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    sym_in = 2'b10;
    repeat (6) tick();
    // A=35, B=20, positive signs
    load_cfg({wf(0,0), wf(0,0), wf(0,0), wf(0,20), wf(0,35)});
    chk(crs_en == 7'b0, "R9 old weights right after load", crs_en, 0);
    tick();
    chk(crs_en == 7'b0000111, "R4 R5 coarse split", crs_en, 7);
    chk(fin_en[3:0] == 4'd3 && fin_en[7:4] == 4'd4, "R4 R6 fine remainder", fin_en[7:0], 8'h43);
    chk(crs_pol[2:0] == 3'b111, "R7 positive polarity", crs_pol, 7);
    chk(out_drive() == 165, "R10 drive 55 x 3", out_drive(), 165);

    // inverted tap A of 16
    load_cfg({wf(0,0), wf(0,0), wf(0,0), wf(0,0), wf(1,16)});
    tick();
    chk(crs_en == 7'b1 && crs_pol[0] == 1'b0, "R7 sign inverts polarity", crs_pol, 0);
    chk(out_drive() == -48, "R10 inverted drive", out_drive(), -48);
    sym_in = 2'b00;
    tick(); tick();
    chk(crs_pol[0] && crs_big[0], "R2 code 00 is -3", {crs_pol[0], crs_big[0]}, 3);
    chk(out_drive() == 48, "R2 R7 drive for code 00", out_drive(), 48);
    sym_in = 2'b11;
    tick(); tick();
    chk(!crs_pol[0] && !crs_big[0], "R2 code 11 is +1", {crs_pol[0], crs_big[0]}, 0);

    // impulse through tap D
    sym_in = 2'b01;
    load_cfg({wf(0,0), wf(0,1), wf(0,0), wf(0,0), wf(0,0)});
    repeat (6) tick();
    sym_in = 2'b10;
    tick();
    sym_in = 2'b01;
    for (int i = 1; i <= 5; i++) begin
      tick();
      p[i] = int'(fin_pol[3]);
    end
    for (int i = 1; i <= 5; i++)
      chk(p[i] == (i == 4 ? 1 : 0), "R3 tap D delay", p[i], (i == 4 ? 1 : 0));
    chk(fin_en[15:12] == 4'd1, "R6 tap D fine bit 0", fin_en[15:12], 1);

    // rejection: sum 128
    load_cfg({wf(0,0), wf(0,0), wf(0,0), wf(0,1), wf(0,127)});
    chk(cfg_err == 1'b1, "R8 flag on sum 128", cfg_err, 1);
    tick();
    chk(fin_en == 20'h01000 && crs_en == 7'b0, "R8 allocation kept", fin_en, 20'h01000);
    // rejection: eight coarse segments
    load_cfg({wf(0,0), wf(0,0), wf(0,0), wf(0,64), wf(0,64)});
    chk(cfg_err == 1'b1, "R8 flag on eight coarse", cfg_err, 1);
    tick();
    chk(fin_en == 20'h01000 && crs_en == 7'b0, "R8 allocation still kept", crs_en, 0);
    // exactly full scale accepted
    load_cfg({wf(0,0), wf(0,0), wf(0,0), wf(0,27), wf(0,100)});
    chk(cfg_err == 1'b0, "R8 flag cleared on accept", cfg_err, 0);
    tick();
    chk(crs_en == 7'h7F, "R5 full pool", crs_en, 7'h7F);
    chk(fin_en[7:0] == 8'hB4, "R6 fine at full scale", fin_en[7:0], 8'hB4);

    // order: C takes 0..2, E takes 3..4
    sym_in = 2'b10;
    repeat (5) tick();
    load_cfg({wf(1,33), wf(0,0), wf(0,48), wf(0,0), wf(0,0)});
    tick();
    chk(crs_en == 7'b0011111, "R5 pool order C then E", crs_en, 7'b0011111);
    chk(crs_pol == 7'b0000111, "R5 R7 owner polarity", crs_pol, 7'b0000111);

    // random regime
    for (int it = 0; it < 40; it++) begin
      rem = 127;
      for (int k = 0; k < 5; k++) begin
        if (it % 3 == 0) mg = $urandom_range(0, 127);
        else begin mg = $urandom_range(0, rem); rem -= mg; end
        rw[k*8 +: 8] = wf(1'($urandom_range(0, 1)), mg);
      end
      load_cfg(rw);
      for (int c = 0; c < 50; c++) begin
        sym_in = 2'($urandom_range(0, 3));
        if (it % 4 == 1) sym_in[0] = 1'b0;
        tick();
      end
    end
    finish_run();
  end
endmodule